// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Divider

This block thins a stream of single-cycle input enable pulses into a slower stream of output enable pulses. The ratio is a fixed-point number: an integer part and a fractional part, held in one 32-bit control word. With the integer part at 2 or more, the fraction counts in sixteenths. With the integer part at exactly 1, the scale narrows to 32 minus the fraction. This gives the finest steps just above a ratio of one. An integer part of zero stops the output.

A bypass bit sends every input pulse straight to the output and ignores the ratio fields. Bypass has its own write port, so software can flip it without a read-modify-write of the whole word.

The divider is a phase accumulator. Every accepted input pulse adds the scale. When the sum reaches the limit (integer times scale plus fraction), the limit is subtracted and one output pulse is emitted on the next cycle. Any write clears the accumulator.

Top module: `frac_rate_divider`

## Requirements
- R1: The control word holds the fraction in bits [3:0], the integer part in bits [15:8] and bypass in bit 23. A full-word write stores all 32 bits. Readback returns the last written word, with bit 23 showing the current bypass state.
- R2: While bypass is set, each accepted in_tick gives exactly one out_tick on the next cycle, and there are no other pulses, whatever the ratio fields hold.
- R3: With bypass clear and an integer part of 0, out_tick never pulses.
- R4: With integer part 1 and fraction f, the scale is 32−f and the limit is 32. N consecutive in_ticks after a clear give floor(N·(32−f)/32) pulses.
- R5: With integer part i ≥ 2 and fraction f, the scale is 16. N consecutive in_ticks after a clear give floor(N·16/(16·i+f)) pulses.
- R6: A write on the bypass-only port changes bit 23 alone. If both ports write in one cycle, the bypass port decides bit 23.
- R7: A write on either port clears the accumulator. An in_tick in the same cycle as a write is discarded and gives no output.
- R8: After reset the control word reads 0, so the output is stopped and bypass is off.
- R9: In divide mode, out_tick is high for one cycle. That cycle directly follows the in_tick whose addition brought the accumulator to or past the limit, and no pulse follows a cycle without such a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Full control-word write strobe |
| cfg_wdata | input | 32 | Control word to write |
| byp_we | input | 1 | Bypass-only write strobe |
| byp_wdata | input | 1 | New bypass value |
| cfg_rdata | output | 32 | Control word readback |
| in_tick | input | 1 | Input enable pulse |
| out_tick | output | 1 | Divided output enable pulse |

## Verification
A configuration write and an accepted input pulse can land in the same cycle. The write must win: the accumulator clears and that pulse is lost. The bench provokes this by raising in_tick together with cfg_we, and also together with byp_we. It does this both mid-division, when the accumulator is one step short of the limit, and under bypass. It judges the result with a behavioural reference that discards such a pulse. That reference is compared with out_tick and cfg_rdata on every cycle. Pulse-count windows then confirm the ratio that follows from the cleared accumulator.

// File: rtl/frdiv_pkg.sv
package frdiv_pkg;

   typedef enum logic [1:0] {
      FRDIV_STOP = 2'd0,
      FRDIV_PASS = 2'd1,
      FRDIV_DIV  = 2'd2
   } frdiv_mode_e;

   localparam int FRDIV_REG_W    = 32;
   localparam int FRDIV_INT_W    = 8;
   localparam int FRDIV_FRAC_W   = 4;
   localparam int FRDIV_INT_LSB  = 8;
   localparam int FRDIV_FRAC_LSB = 0;
   localparam int FRDIV_BYP_BIT  = 23;

endpackage

// File: rtl/frdiv_ctrl_reg.sv
module frdiv_ctrl_reg #(
   parameter int REG_W      = 32,
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 4,
   parameter int INT_LSB    = 8,
   parameter int FRAC_LSB   = 0,
   parameter int BYP_BIT    = 23,
   parameter bit KEEP_SPARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              byp_we,
   input  logic              byp_wdata,
   output logic [REG_W-1:0]  rdata_o,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic              byp_o,
   output logic              touch_o
);

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic              byp_q;
   logic [REG_W-1:0]  base_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q  <= '0;
         frac_q <= '0;
         byp_q  <= 1'b0;
      end else begin
         if (cfg_we) begin
            int_q  <= cfg_wdata[INT_LSB +: INT_W];
            frac_q <= cfg_wdata[FRAC_LSB +: FRAC_W];
            byp_q  <= cfg_wdata[BYP_BIT];
         end
         if (byp_we) begin
            byp_q <= byp_wdata;
         end
      end
   end

   generate
      if (KEEP_SPARE) begin : g_spare
         logic [REG_W-1:0] spare_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               spare_q <= '0;
            end else if (cfg_we) begin
               spare_q <= cfg_wdata;
            end
         end
         assign base_w = spare_q;
      end else begin : g_nospare
         assign base_w = '0;
      end
   endgenerate

   always_comb begin
      rdata_o                       = base_w;
      rdata_o[INT_LSB +: INT_W]     = int_q;
      rdata_o[FRAC_LSB +: FRAC_W]   = frac_q;
      rdata_o[BYP_BIT]              = byp_q;
   end

   assign int_o   = int_q;
   assign frac_o  = frac_q;
   assign byp_o   = byp_q;
   assign touch_o = cfg_we | byp_we;

   // R6: the bypass-only port leaves the ratio fields alone
   p_byp_port_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_we && !cfg_we) |=> ($stable(int_q) && $stable(frac_q)));

   // R6: the bypass port decides bit 23 when both ports write
   p_byp_port_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      byp_we |=> (rdata_o[BYP_BIT] == $past(byp_wdata)));

endmodule

// File: rtl/frdiv_ratio.sv
module frdiv_ratio
   import frdiv_pkg::*;
#(
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 4,
   parameter bit NARROW_ONE = 1'b1,
   parameter int ACC_W      = INT_W + FRAC_W + 1
) (
   input  logic [INT_W-1:0]  int_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              byp_i,
   output frdiv_mode_e       mode_o,
   output logic [ACC_W-1:0]  step_o,
   output logic [ACC_W-1:0]  limit_o
);

   localparam int BASE = 1 << FRAC_W;

   logic [ACC_W-1:0] frac_ext;
   logic [ACC_W-1:0] int_ext;

   assign frac_ext = ACC_W'(frac_i);
   assign int_ext  = ACC_W'(int_i);

   always_comb begin
      if (byp_i) begin
         mode_o = FRDIV_PASS;
      end else if (int_i == '0) begin
         mode_o = FRDIV_STOP;
      end else begin
         mode_o = FRDIV_DIV;
      end
   end

   generate
      if (NARROW_ONE) begin : g_narrow
         always_comb begin
            if (int_i == INT_W'(1)) begin
               step_o = ACC_W'(2 * BASE) - frac_ext;
            end else begin
               step_o = ACC_W'(BASE);
            end
         end
      end else begin : g_flat
         assign step_o = ACC_W'(BASE);
      end
   endgenerate

   assign limit_o = (int_ext * step_o) + frac_ext;

endmodule

// File: rtl/frdiv_accum.sv
module frdiv_accum
   import frdiv_pkg::*;
#(
   parameter int ACC_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  frdiv_mode_e      mode_i,
   input  logic [ACC_W-1:0] step_i,
   input  logic [ACC_W-1:0] limit_i,
   output logic             tick_o
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   assign sum = {1'b0, acc_q} + {1'b0, step_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= 1'b0;
         if (clr_i) begin
            acc_q <= '0;
         end else if (tick_i) begin
            unique case (mode_i)
               FRDIV_PASS: tick_o <= 1'b1;
               FRDIV_DIV: begin
                  if (sum >= {1'b0, limit_i}) begin
                     acc_q  <= ACC_W'(sum - {1'b0, limit_i});
                     tick_o <= 1'b1;
                  end else begin
                     acc_q <= sum[ACC_W-1:0];
                  end
               end
               default: acc_q <= acc_q;
            endcase
         end
      end
   end

   // R5: the phase stays below the limit while dividing
   p_acc_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == FRDIV_DIV) |-> (acc_q < limit_i));

   // R7: a write empties the accumulator and drops the pulse
   p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ((acc_q == '0) && !tick_o));

   // R2: bypass forwards every accepted pulse one cycle later
   p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == FRDIV_PASS) && tick_i && !clr_i) |=> tick_o);

   // R3: no pulse when stopped or without an input pulse
   p_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == FRDIV_STOP) || !tick_i || clr_i) |=> !tick_o);

endmodule

// File: rtl/frac_rate_divider.sv
module frac_rate_divider
   import frdiv_pkg::*;
#(
   parameter int REG_W      = FRDIV_REG_W,
   parameter int INT_W      = FRDIV_INT_W,
   parameter int FRAC_W     = FRDIV_FRAC_W,
   parameter int INT_LSB    = FRDIV_INT_LSB,
   parameter int FRAC_LSB   = FRDIV_FRAC_LSB,
   parameter int BYP_BIT    = FRDIV_BYP_BIT,
   parameter bit KEEP_SPARE = 1'b1,
   parameter bit NARROW_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             byp_we,
   input  logic             byp_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             in_tick,
   output logic             out_tick
);

   localparam int ACC_W = INT_W + FRAC_W + 1;

   generate
      if (INT_LSB + INT_W > REG_W || FRAC_LSB + FRAC_W > REG_W || BYP_BIT >= REG_W) begin : g_bad_span
         $error("frac_rate_divider: a field lies outside the control word");
      end
      if (FRAC_LSB + FRAC_W > INT_LSB && INT_LSB + INT_W > FRAC_LSB) begin : g_bad_overlap
         $error("frac_rate_divider: integer and fraction fields overlap");
      end
      if ((BYP_BIT >= INT_LSB && BYP_BIT < INT_LSB + INT_W) ||
          (BYP_BIT >= FRAC_LSB && BYP_BIT < FRAC_LSB + FRAC_W)) begin : g_bad_byp
         $error("frac_rate_divider: bypass bit collides with a ratio field");
      end
      if (INT_W < 2 || FRAC_W < 1) begin : g_bad_width
         $error("frac_rate_divider: field widths too small");
      end
   endgenerate

   logic [INT_W-1:0]  int_w;
   logic [FRAC_W-1:0] frac_w;
   logic              byp_w;
   logic              touch_w;
   frdiv_mode_e       mode_w;
   logic [ACC_W-1:0]  step_w;
   logic [ACC_W-1:0]  limit_w;

   frdiv_ctrl_reg #(
      .REG_W      (REG_W),
      .INT_W      (INT_W),
      .FRAC_W     (FRAC_W),
      .INT_LSB    (INT_LSB),
      .FRAC_LSB   (FRAC_LSB),
      .BYP_BIT    (BYP_BIT),
      .KEEP_SPARE (KEEP_SPARE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .byp_we    (byp_we),
      .byp_wdata (byp_wdata),
      .rdata_o   (cfg_rdata),
      .int_o     (int_w),
      .frac_o    (frac_w),
      .byp_o     (byp_w),
      .touch_o   (touch_w)
   );

   frdiv_ratio #(
      .INT_W      (INT_W),
      .FRAC_W     (FRAC_W),
      .NARROW_ONE (NARROW_ONE),
      .ACC_W      (ACC_W)
   ) u_ratio (
      .int_i   (int_w),
      .frac_i  (frac_w),
      .byp_i   (byp_w),
      .mode_o  (mode_w),
      .step_o  (step_w),
      .limit_o (limit_w)
   );

   frdiv_accum #(
      .ACC_W (ACC_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (touch_w),
      .tick_i  (in_tick),
      .mode_i  (mode_w),
      .step_i  (step_w),
      .limit_i (limit_w),
      .tick_o  (out_tick)
   );

   // R4: one subtraction always suffices, so the step never exceeds the limit
   p_step_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == FRDIV_DIV) |-> ((step_w <= limit_w) && (step_w != '0)));

   // R3: a pulse needs bypass or a nonzero integer part in the cycle before
   p_zero_int_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(cfg_rdata[BYP_BIT] || (cfg_rdata[INT_LSB +: INT_W] != '0)));

endmodule

// File: tb/tb_frac_rate_divider.sv
`timescale 1ns/1ps
module tb_frac_rate_divider;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        byp_we = 1'b0;
   logic        byp_wdata = 1'b0;
   logic [31:0] cfg_rdata;
   logic        in_tick = 1'b0;
   logic        out_tick;

   int checks = 0;
   int fails = 0;
   int pulse_cnt = 0;
   bit done = 1'b0;

   logic [31:0] reg_m = '0;
   int          acc_m = 0;

   always #2 clk = ~clk;

   frac_rate_divider dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .byp_we    (byp_we),
      .byp_wdata (byp_wdata),
      .cfg_rdata (cfg_rdata),
      .in_tick   (in_tick),
      .out_tick  (out_tick)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock of stimulus, reference update and comparison
   task automatic step(input bit we, input logic [31:0] wd, input bit bwe,
                       input bit bd, input bit tk, input string tag);
      bit exp_out;
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; byp_we = bwe; byp_wdata = bd; in_tick = tk;
      exp_out = 1'b0;
      if (we || bwe) begin
         if (we) reg_m = wd;
         if (bwe) reg_m[23] = bd;
         acc_m = 0;
      end else if (tk) begin
         if (reg_m[23]) begin
            exp_out = 1'b1;
         end else if (reg_m[15:8] != 0) begin
            int ii = int'(reg_m[15:8]);
            int ff = int'(reg_m[3:0]);
            int sc = (ii == 1) ? 32 - ff : 16;
            int lim = ii * sc + ff;
            acc_m += sc;
            if (acc_m >= lim) begin
               acc_m -= lim;
               exp_out = 1'b1;
            end
         end
      end
      @(posedge clk);
      #1;
      cfg_we = 1'b0; byp_we = 1'b0; in_tick = 1'b0;
      if (out_tick) pulse_cnt++;
      chk(out_tick == exp_out, tag, "out_tick", longint'(out_tick), longint'(exp_out));
      chk(cfg_rdata == reg_m, "R1", "cfg_rdata", longint'(cfg_rdata), longint'(reg_m));
   endtask

   task automatic run_window(input logic [31:0] word, input int n, input int exp_pulses,
                             input string tag);
      step(1'b1, word, 1'b0, 1'b0, 1'b0, tag);
      pulse_cnt = 0;
      for (int k = 0; k < n; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R9");
      step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R9");
      chk(pulse_cnt == exp_pulses, tag, "pulse count", pulse_cnt, exp_pulses);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      reg_m = '0;
      acc_m = 0;
      #1;
      chk(cfg_rdata == 32'h0, "R8", "rdata after reset", longint'(cfg_rdata), 0);
      chk(out_tick == 1'b0, "R8", "out_tick after reset", longint'(out_tick), 0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      do_reset();
      // R8: stopped after reset even with input pulses
      for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");

      // R3: integer part zero with a nonzero fraction
      step(1'b1, 32'h0000_000F, 1'b0, 1'b0, 1'b0, "R3");
      for (int k = 0; k < 20; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R3");

      // R2: bypass through the full word, ratio fields hold a divide setting
      step(1'b1, 32'h0080_0305, 1'b0, 1'b0, 1'b0, "R2");
      for (int k = 0; k < 24; k++) step(1'b0, '0, 1'b0, 1'b0, (k % 3) != 1, "R2");

      // R6: clear bypass through its own port; fields must survive
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R6");
      chk(cfg_rdata == 32'h0000_0305, "R6", "fields after bypass write",
          longint'(cfg_rdata), 32'h0000_0305);
      pulse_cnt = 0;
      for (int k = 0; k < 106; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R9");
      step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R9");
      chk(pulse_cnt == 32, "R5", "i=3 f=5 pulses", pulse_cnt, 32);

      // R4: integer part one, several fractions
      run_window(32'h0000_010F, 64, 34, "R4");
      run_window(32'h0000_0100, 10, 10, "R4");
      run_window(32'h0000_0108, 32, 24, "R4");

      // R5: larger integer parts
      run_window(32'h0000_0208, 80, 32, "R5");
      run_window(32'h0000_FF0F, 512, 2, "R5");
      run_window(32'h0000_0400, 40, 10, "R5");

      // R7: write in the same cycle as an input pulse, mid-division
      step(1'b1, 32'h0000_0100, 1'b0, 1'b0, 1'b0, "R7");
      step(1'b1, 32'h0000_0201, 1'b0, 1'b0, 1'b1, "R7");
      for (int k = 0; k < 2; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");
      step(1'b1, 32'h0000_0201, 1'b0, 1'b0, 1'b1, "R7");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");
      // bypass write that keeps the same value still clears and drops
      step(1'b0, '0, 1'b1, 1'b0, 1'b1, "R7");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");

      // R7: bypass set together with a pulse, then pulses forwarded
      step(1'b0, '0, 1'b1, 1'b1, 1'b1, "R7");
      for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R2");
      // R6: both ports in one cycle, bypass port decides bit 23
      step(1'b1, 32'h0080_0000, 1'b1, 1'b0, 1'b1, "R6");
      chk(cfg_rdata[23] == 1'b0, "R6", "bit 23 with both ports",
          longint'(cfg_rdata[23]), 0);
      for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R3");

      // R1: spare bits read back as written
      step(1'b1, 32'hA5F0_7E3C, 1'b0, 1'b0, 1'b0, "R1");
      chk(cfg_rdata == 32'hA5F0_7E3C, "R1", "full word readback",
          longint'(cfg_rdata), 32'hA5F0_7E3C);
      for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R2");

      do_reset();
      for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule